// File: doc/BRIEF.md
# Dual-Mode ADC Result FIFO

This block sits between an ADC sampling front end and two consumers: a 32-bit register read port and a 64-bit drain port meant for a DMA engine. The front end offers one 32-bit tagged result per conversion. In a valid word, bit 30 carries the sequencer-running status and bits 15:0 carry the two's-complement conversion value; the block passes these bits through unchanged. A mode input picks the storage layout. In single mode, used for software-started conversions, every stored entry is one word. In paired mode, used for timed or externally started conversions, two consecutive words are packed into one 64-bit entry. The earlier word goes in the low half.

The write port uses valid/ready, but the front end cannot stall. `in_ready` tells it whether a word offered this cycle will be kept. A word offered while `in_ready` is low is dropped and the sticky `overflow` flag is set, except in the cycle where the mode changes. The drain port is valid/ready with ordinary back-pressure: `dma_data` and `dma_valid` hold until `dma_ready` is seen.

The count is reported in entries, not in words. A level interrupt tracks the count against a programmable threshold. A register read of an empty FIFO returns an invalid marker word instead of stale data.

Top module: `adc_result_fifo`

## Requirements
- R1: After reset the block is in this state: `fifo_count` is 0, `overflow` is 0, `dma_valid` is 0, `reg_rdata` is 32'h8000_0000, and `in_ready` is 1 with `mode_paired` low.
- R2: Single mode (`mode_paired`=0): each accepted word becomes one entry. Each `reg_rd` on a non-empty FIFO pops the oldest entry. The read returns that entry's word with bit 31 forced to 0 and bits 30:0 as written.
- R3: Paired mode: the first word of a pair waits in a staging register and is not counted. When the second word is accepted, one entry {second word, first word} is stored, with the first word in bits 31:0.
- R4: Paired mode, register port: the first `reg_rd` on an entry returns bits 31:0 and does not pop. The second `reg_rd` returns bits 63:32 and pops. Bit 31 of each returned word reads 0.
- R5: `dma_valid` is high only when all of these hold: paired mode, count non-zero, no entry half-read through the register port, `reg_rd` low, and no mode change in this cycle. `dma_data` is the whole oldest 64-bit entry. A cycle with `dma_valid` and `dma_ready` both high pops it.
- R6: A `reg_rd` while `fifo_count` is 0 returns 32'h8000_0000 (bit 31 = invalid) and changes no state.
- R7: `fifo_count` (12 bits) is the number of stored entries, up to DEPTH (default 4095). A push and a pop in the same cycle leave it unchanged.
- R8: `almost_full` is high exactly while `fifo_count` >= `af_threshold`. A threshold of 0 keeps it high.
- R9: Full means `fifo_count` = DEPTH at the start of the cycle. `in_ready` is low when the FIFO is full in single mode. In paired mode it is low only when the FIFO is full and a first word is already staged. A word offered while `in_ready` is low is dropped, and `overflow` is set and stays set until reset.
- R10: In any cycle where `mode_paired` differs from its value in the previous cycle, the FIFO, the staging register and any half-read state are cleared. That cycle's write, register read and drain are all ignored, and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_paired | input | 1 | 0 = single-word entries, 1 = packed pairs |
| in_valid | input | 1 | Conversion word offered |
| in_ready | output | 1 | Offered word will be kept |
| in_data | input | 32 | Tagged conversion word |
| reg_rd | input | 1 | Register read strobe, one word per cycle |
| reg_rdata | output | 32 | Word returned by a read in this cycle |
| dma_valid | output | 1 | A full 64-bit entry is offered |
| dma_ready | input | 1 | Drain accepts the entry |
| dma_data | output | 64 | Oldest entry |
| af_threshold | input | 12 | Almost-full level in entries |
| fifo_count | output | 12 | Stored entries |
| almost_full | output | 1 | Count at or above threshold |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
Single mode is driven with mixed random writes and reads, so pushes, pops, simultaneous push-pop and empty reads interleave. This separates a wrong count from wrong data ordering. Continuous writes past DEPTH, followed by a drain that overruns into empty reads, show the full, overflow and invalid-marker behaviour. Paired mode runs three ways: with the register port only, to expose half ordering; with the drain only, to expose packing; and with both together, to test the arbitration between them. A short sequence stages an odd word and then flips the mode, which shows whether the staging register is flushed.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ENTRY_W = 2 * WORD_W;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [ENTRY_W-1:0] entry_t;

  // Marker returned when the register port reads an empty store
  localparam word_t INVALID_WORD = word_t'(1) << (WORD_W - 1);
endpackage

// File: rtl/adc_fifo_pack.sv
module adc_fifo_pack
  import adc_fifo_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flush,
  input  logic   paired,
  input  logic   full,
  input  logic   in_valid,
  input  word_t  in_data,
  output logic   in_ready,
  output logic   push,
  output entry_t push_data,
  output logic   drop
);
  logic  stage_vld;
  word_t stage_q;
  logic  take;

  assign in_ready  = !flush && (paired ? (!stage_vld || !full) : !full);
  assign take      = in_valid && in_ready;
  assign drop      = in_valid && !flush && !in_ready;
  assign push      = take && (!paired || stage_vld);
  assign push_data = paired ? {in_data, stage_q} : {{WORD_W{1'b0}}, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_vld <= 1'b0;
      stage_q   <= '0;
    end else if (flush) begin
      stage_vld <= 1'b0;
    end else if (take && paired) begin
      stage_vld <= !stage_vld;
      if (!stage_vld) stage_q <= in_data;
    end
  end

  // R3
  stage_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paired && !flush && in_valid && !stage_vld) |=> (stage_vld && stage_q == $past(in_data)));
endmodule

// File: rtl/adc_fifo_store.sv
module adc_fifo_store
  import adc_fifo_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DEPTH = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  entry_t           wdata,
  input  logic             pop,
  output entry_t           rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  entry_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  // R7
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R7
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !flush) |=> $stable(count));
  // R9
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R6
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/adc_fifo_rdsel.sv
module adc_fifo_rdsel
  import adc_fifo_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flush,
  input  logic   paired,
  input  logic   empty,
  input  entry_t head,
  input  logic   reg_rd,
  output word_t  reg_rdata,
  input  logic   dma_ready,
  output logic   dma_valid,
  output entry_t dma_data,
  output logic   pop
);
  logic  half_q;
  logic  rd_ok;
  logic  reg_pop;
  word_t sel;

  assign rd_ok     = reg_rd && !empty && !flush;
  assign reg_pop   = rd_ok && (!paired || half_q);
  assign dma_valid = !flush && paired && !empty && !half_q && !reg_rd;
  assign dma_data  = head;
  assign pop       = reg_pop || (dma_valid && dma_ready);

  assign sel       = (paired && half_q) ? head[ENTRY_W-1:WORD_W] : head[WORD_W-1:0];
  assign reg_rdata = empty ? INVALID_WORD : {1'b0, sel[WORD_W-2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n || flush) half_q <= 1'b0;
    else if (rd_ok && paired) half_q <= !half_q;
  end

  // R4
  half_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_q && !flush) |-> !empty);
  // R4
  half_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paired && reg_rd && !empty && !flush && !half_q) |=> half_q);
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo
  import adc_fifo_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DEPTH = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_paired,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  input  logic             reg_rd,
  output logic [31:0]      reg_rdata,
  output logic             dma_valid,
  input  logic             dma_ready,
  output logic [63:0]      dma_data,
  input  logic [CNT_W-1:0] af_threshold,
  output logic [CNT_W-1:0] fifo_count,
  output logic             almost_full,
  output logic             overflow
);
  logic   mode_q, flush;
  logic   push, pop, drop, full, empty;
  entry_t push_data, head;

  assign flush = (mode_paired != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      mode_q <= mode_paired;
      if (drop) overflow <= 1'b1;
    end
  end

  adc_fifo_pack u_pack (
    .clk, .rst_n, .flush,
    .paired    (mode_paired),
    .full,
    .in_valid,
    .in_data,
    .in_ready,
    .push,
    .push_data,
    .drop
  );

  adc_fifo_store #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_store (
    .clk, .rst_n, .flush,
    .push,
    .wdata (push_data),
    .pop,
    .rdata (head),
    .count (fifo_count),
    .full,
    .empty
  );

  adc_fifo_rdsel u_rdsel (
    .clk, .rst_n, .flush,
    .paired (mode_paired),
    .empty,
    .head,
    .reg_rd,
    .reg_rdata,
    .dma_ready,
    .dma_valid,
    .dma_data,
    .pop
  );

  assign almost_full = (fifo_count >= af_threshold);

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fifo_count == '0));
  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R5
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid |-> (mode_paired && !reg_rd && fifo_count != '0));
  // R5
  dma_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && dma_ready && !push) |=> (fifo_count == $past(fifo_count) - 1'b1));
endmodule

// File: tb/adc_result_fifo_tb_top.sv
module adc_result_fifo_tb_top;
  localparam int CNT_W = 12;
  localparam int DEPTH = 4095;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             mode_paired, in_valid, in_ready, reg_rd, dma_valid, dma_ready;
  logic [31:0]      in_data, reg_rdata;
  logic [63:0]      dma_data;
  logic [CNT_W-1:0] af_threshold, fifo_count;
  logic             almost_full, overflow;

  always #5 clk = ~clk;

  adc_result_fifo #(.CNT_W(CNT_W), .DEPTH(DEPTH)) dut_i (
    .clk, .rst_n, .mode_paired, .in_valid, .in_ready, .in_data,
    .reg_rd, .reg_rdata, .dma_valid, .dma_ready, .dma_data,
    .af_threshold, .fifo_count, .almost_full, .overflow
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  logic [63:0] q[$];
  bit          stage_v, half_m, ovf_m, prev_m;
  logic [31:0] stage_w;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // inputs already driven after a falling edge; compare, then advance model
  task automatic step();
    bit fl, full, rdy, dv;
    int cnt;
    logic [31:0] w;
    #1;
    fl   = (mode_paired != prev_m);
    cnt  = q.size();
    full = (cnt == DEPTH);
    rdy  = fl ? 1'b0 : (mode_paired ? (!stage_v || !full) : !full);
    dv   = !fl && mode_paired && cnt > 0 && !half_m && !reg_rd;

    chk("R7", "fifo_count", 64'(fifo_count), 64'(cnt));
    chk("R8", "almost_full", 64'(almost_full), 64'(cnt >= int'(af_threshold)));
    chk("R9", "overflow", 64'(overflow), 64'(ovf_m));
    chk(fl ? "R10" : "R9", "in_ready", 64'(in_ready), 64'(rdy));
    chk(fl ? "R10" : "R5", "dma_valid", 64'(dma_valid), 64'(dv));
    if (dv) chk("R3", "dma_data", dma_data, q[0]);
    if (!fl) begin
      if (cnt == 0) chk("R6", "reg_rdata", 64'(reg_rdata), 64'h8000_0000);
      else begin
        w = (mode_paired && half_m) ? q[0][63:32] : q[0][31:0];
        w[31] = 1'b0;
        chk(mode_paired ? "R4" : "R2", "reg_rdata", 64'(reg_rdata), 64'(w));
      end
    end

    if (fl) begin
      q.delete();
      stage_v = 0;
      half_m  = 0;
    end else begin
      if (reg_rd && cnt > 0) begin
        if (mode_paired && !half_m) half_m = 1;
        else begin
          void'(q.pop_front());
          half_m = 0;
        end
      end else if (dv && dma_ready) begin
        void'(q.pop_front());
      end
      if (in_valid) begin
        if (!rdy) ovf_m = 1;
        else if (!mode_paired) q.push_back({32'h0, in_data});
        else if (stage_v) begin
          q.push_back({in_data, stage_w});
          stage_v = 0;
        end else begin
          stage_w = in_data;
          stage_v = 1;
        end
      end
    end
    prev_m = mode_paired;
    @(negedge clk);
  endtask

  task automatic run(input int n, input bit mode, input int p_in, input int p_rd,
                     input int p_dma, input int thr);
    for (int i = 0; i < n; i++) begin
      mode_paired  = mode;
      af_threshold = CNT_W'(thr);
      in_valid     = ($urandom_range(99) < p_in);
      in_data      = $urandom;
      reg_rd       = ($urandom_range(99) < p_rd);
      dma_ready    = ($urandom_range(99) < p_dma);
      step();
    end
  endtask

  bit finished = 0;

  initial begin
    rst_n = 0; mode_paired = 0; in_valid = 0; in_data = '0;
    reg_rd = 0; dma_ready = 0; af_threshold = 12'd5;
    stage_v = 0; half_m = 0; ovf_m = 0; prev_m = 0; stage_w = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "count", 64'(fifo_count), 64'd0);
    chk("R1", "overflow", 64'(overflow), 64'd0);
    chk("R1", "dma_valid", 64'(dma_valid), 64'd0);
    chk("R1", "reg_rdata", 64'(reg_rdata), 64'h8000_0000);
    chk("R1", "in_ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    rst_n = 1;

    // R2/R6/R7: single-word mixed traffic
    run(800, 0, 50, 45, 0, 5);
    // R9: fill past capacity, then drain into empty reads (R6)
    run(DEPTH + 20, 0, 100, 0, 0, 4000);
    run(DEPTH + 30, 0, 0, 100, 0, 0);
    // R3/R4: paired, register port only
    run(1200, 1, 55, 40, 0, 3);
    // R3/R5: paired, drain only
    run(1200, 1, 50, 0, 60, 7);
    // R5: both consumers competing
    run(1500, 1, 60, 25, 50, 2);
    run(300, 1, 0, 50, 50, 1);

    // R10: stage an odd word, flip the mode, confirm staging is gone
    run(5, 1, 0, 100, 100, 0);
    in_valid = 1; reg_rd = 0; dma_ready = 0;
    for (int i = 0; i < 3; i++) begin in_data = $urandom; step(); end
    in_valid = 0; mode_paired = 0; step();
    chk("R10", "count after flush", 64'(fifo_count), 64'd0);
    mode_paired = 1; step();
    in_valid = 1; in_data = 32'h1234_5678; step();
    in_valid = 0; step();
    chk("R10", "staging flushed", 64'(fifo_count), 64'd0);
    in_valid = 1; in_data = 32'h0bad_cafe; step();
    in_valid = 0; step();
    chk("R3", "pair complete", 64'(fifo_count), 64'd1);

    // R9: paired fill past capacity, then drain
    run(2 * DEPTH + 20, 1, 100, 0, 0, DEPTH);
    run(DEPTH + 20, 1, 0, 0, 100, 0);
    run(50, 1, 0, 100, 0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule